// File: doc/BRIEF.md
# Segment Column Data Loader

This block takes the display data for one line of a 160-column panel driver from a shared parallel bus, four or eight bits per shift clock, and writes it into a 160-bit data latch one byte at a time. The fill direction is set by an input: columns fill either from the first column upward or from the last column downward. On the falling edge of the line latch pulse the whole data latch is copied in one step into a line latch, and the load logic is rearmed for the next line. For each column the block then emits a 2-bit drive-level code formed from the line latch bit and the frame inversion input.

Several loaders can share one bus through a daisy chain of active-low select links. A loader starts taking data once its incoming link is seen low, takes exactly its 160-column quota, and then hands over to the next loader with a low pulse lasting one shift-clock period. The shift clock and latch pulse are plain inputs that the block samples with its system clock; their falling edges are found by synchronous edge detectors. The data path has no back-pressure: the bus master owns the pace, and each detected shift-clock fall is either taken or ignored, never stalled, so no valid/ready handshake exists at the edge.

Top module: `seg_line_loader`

## Requirements
- R1: With `wide_mode` low, each shift-clock fall carries four bits on `bus_data[3:0]`; two consecutive nibbles form one byte, the first nibble holding byte bits 0..3 and the second bits 4..7, so a line takes 40 shift clocks.
- R2: With `wide_mode` high, each shift-clock fall carries a whole byte on `bus_data[7:0]`, so a line takes 20 shift clocks.
- R3: Bus data is taken from the system-clock cycle in which `shift_clk` is first sampled low after being sampled high; bus values in other cycles have no effect.
- R4: Byte k of a line (k = 0..19) bit i goes to column 8k+i when `fill_up` is high and to column 159-8k-i when `fill_up` is low; column c is reported on `col_level[2c+1:2c]`.
- R5: After a latch pulse fall the loader ignores shift-clock falls until one arrives while its incoming link is low (link A when `fill_up` is high, link B when low); from then on it takes data regardless of the link until 160 bits are in, and ignores all further shift-clock falls until the next latch pulse fall.
- R6: The outgoing link (B when `fill_up` is high, A when low) has its enable high and idles high; in the cycle after the shift-clock fall that completes the 160th bit it goes low, and it returns high in the cycle after the next shift-clock fall. The incoming link's enable is low and its output stays high.
- R7: On a latch pulse fall all 160 data-latch bits are copied to the line latch together; the line latch keeps its value at all other times while `blank_n` is high.
- R8: While `blank_n` is low the line latch is cleared and every column reads code 3, while the data latch still loads; once `blank_n` is high again the columns show the cleared line until the next latch pulse fall.
- R9: Level codes are V0=0, V12=1, V43=2, V5=3; with `blank_n` high, `frame_inv` low gives 2 for a 0 bit and 3 for a 1 bit, and `frame_inv` high gives 1 for a 0 bit and 0 for a 1 bit.
- R10: An active-low `rst_n` clears both latches and leaves the loader deselected with its quota spent, so no data is taken before the first latch pulse fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_clk | input | 1 | Bus shift clock, sampled |
| bus_data | input | 8 | Parallel display data |
| wide_mode | input | 1 | 1: eight bits per shift clock, 0: four bits |
| fill_up | input | 1 | 1: fill from column 0 upward, 0: from column 159 downward |
| latch_pulse | input | 1 | Line latch pulse, sampled |
| blank_n | input | 1 | Active-low display blanking |
| frame_inv | input | 1 | Frame inversion signal |
| link_a_in | input | 1 | Link A input value |
| link_a_out | output | 1 | Link A output value |
| link_a_oe | output | 1 | Link A drive enable |
| link_b_in | input | 1 | Link B input value |
| link_b_out | output | 1 | Link B output value |
| link_b_oe | output | 1 | Link B drive enable |
| col_level | output | 320 | Per-column 2-bit drive level code |

## Verification
The bench goes after the nibble pairing order in four-bit mode, where swapping the halves would scramble every group of eight columns, and after the mirrored placement when filling downward, where an off-by-one would shift the whole line by a column. It feeds shift clocks before the incoming link drops and after the quota is spent, which a loader with a loose select rule would absorb into the line, and it times the handover pulse, which a wrong design would hold for a single system cycle or leave low. Blanking is exercised across a latch pulse to catch a design that lets the line latch load while blanked or stops the data latch from loading.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;
  typedef enum logic [1:0] {
    LVL_V0  = 2'd0,
    LVL_V12 = 2'd1,
    LVL_V43 = 2'd2,
    LVL_V5  = 2'd3
  } level_e;

  function automatic level_e pick_level(input logic blank_n, input logic inv, input logic bit_on);
    if (!blank_n)  return LVL_V5;
    else if (inv)  return bit_on ? LVL_V0 : LVL_V12;
    else           return bit_on ? LVL_V5 : LVL_V43;
  endfunction
endpackage

// File: rtl/seg_fall_detect.sv
module seg_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end

  assign fall = prev_q & ~sig;
endmodule

// File: rtl/seg_load_ctrl.sv
module seg_load_ctrl #(
  parameter int COLS = 160,
  parameter int BYTES = COLS / 8,
  parameter int CW = $clog2(BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_fall,
  input  logic          lp_fall,
  input  logic          link_in,
  input  logic          wide_mode,
  input  logic [7:0]    bus_data,
  output logic          wr_en,
  output logic [CW-1:0] wr_idx,
  output logic [7:0]    wr_byte,
  output logic          handoff
);
  localparam logic [CW-1:0] LAST = CW'(BYTES - 1);

  logic [CW-1:0] cnt_q;
  logic          half_q, sel_q, done_q, pulse_q;
  logic [3:0]    nib_q;
  logic          accept, byte_ready;

  assign accept     = s_fall & ~lp_fall & ~done_q & (sel_q | ~link_in);
  assign byte_ready = wide_mode | half_q;
  assign wr_en      = accept & byte_ready;
  assign wr_idx     = cnt_q;
  assign wr_byte    = wide_mode ? bus_data : {bus_data[3:0], nib_q};
  assign handoff    = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; half_q <= 1'b0; nib_q <= '0;
      sel_q <= 1'b0; done_q <= 1'b1; pulse_q <= 1'b0;
    end else if (lp_fall) begin
      cnt_q <= '0; half_q <= 1'b0;
      sel_q <= 1'b0; done_q <= 1'b0; pulse_q <= 1'b0;
    end else if (s_fall) begin
      pulse_q <= 1'b0;
      if (accept) begin
        sel_q <= 1'b1;
        if (byte_ready) begin
          half_q <= 1'b0;
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            done_q  <= 1'b1;
            sel_q   <= 1'b0;
            pulse_q <= 1'b1;
          end
        end else begin
          half_q <= 1'b1;
          nib_q  <= bus_data[3:0];
        end
      end
    end
  end

  // R5
  quota_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(BYTES));
  // R5
  no_write_after_quota_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !wr_en);
  // R6
  handoff_one_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && s_fall) |=> !pulse_q);
  // R7
  line_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp_fall |=> (cnt_q == '0 && !sel_q && !done_q && !pulse_q));
endmodule

// File: rtl/seg_data_latch.sv
module seg_data_latch #(
  parameter int COLS = 160,
  parameter int BYTES = COLS / 8,
  parameter int CW = $clog2(BYTES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_up,
  input  logic            wr_en,
  input  logic [CW-1:0]   wr_idx,
  input  logic [7:0]      wr_byte,
  output logic [COLS-1:0] data_q
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int UP_SLOT = c / 8;
    localparam int UP_BIT  = c % 8;
    localparam int DN_SLOT = (COLS - 1 - c) / 8;
    localparam int DN_BIT  = (COLS - 1 - c) % 8;
    logic hit;
    assign hit = wr_en && (wr_idx == (fill_up ? CW'(UP_SLOT) : CW'(DN_SLOT)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   data_q[c] <= 1'b0;
      else if (hit) data_q[c] <= fill_up ? wr_byte[UP_BIT] : wr_byte[DN_BIT];
    end
  end
endmodule

// File: rtl/seg_level_map.sv
module seg_level_map
  import seg_loader_pkg::*;
#(
  parameter int COLS = 160
) (
  input  logic [COLS-1:0]   line_q,
  input  logic              blank_n,
  input  logic              frame_inv,
  output logic [2*COLS-1:0] col_level
);
  for (genvar c = 0; c < COLS; c++) begin : g_lvl
    assign col_level[2*c +: 2] = pick_level(blank_n, frame_inv, line_q[c]);
  end
endmodule

// File: rtl/seg_line_loader.sv
module seg_line_loader #(
  parameter int COLS = 160,
  localparam int BYTES = COLS / 8,
  localparam int CW = $clog2(BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_clk,
  input  logic [7:0]        bus_data,
  input  logic              wide_mode,
  input  logic              fill_up,
  input  logic              latch_pulse,
  input  logic              blank_n,
  input  logic              frame_inv,
  input  logic              link_a_in,
  output logic              link_a_out,
  output logic              link_a_oe,
  input  logic              link_b_in,
  output logic              link_b_out,
  output logic              link_b_oe,
  output logic [2*COLS-1:0] col_level
);
  logic            s_fall, lp_fall, link_in, handoff, wr_en;
  logic [CW-1:0]   wr_idx;
  logic [7:0]      wr_byte;
  logic [COLS-1:0] data_q, line_q;

  seg_fall_detect u_sclk_det (.clk(clk), .rst_n(rst_n), .sig(shift_clk),   .fall(s_fall));
  seg_fall_detect u_lp_det   (.clk(clk), .rst_n(rst_n), .sig(latch_pulse), .fall(lp_fall));

  assign link_in    = fill_up ? link_a_in : link_b_in;
  assign link_a_oe  = ~fill_up;
  assign link_b_oe  = fill_up;
  assign link_a_out = fill_up ? 1'b1 : ~handoff;
  assign link_b_out = fill_up ? ~handoff : 1'b1;

  seg_load_ctrl #(.COLS(COLS), .BYTES(BYTES), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .s_fall(s_fall), .lp_fall(lp_fall),
    .link_in(link_in), .wide_mode(wide_mode), .bus_data(bus_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte), .handoff(handoff)
  );

  seg_data_latch #(.COLS(COLS), .BYTES(BYTES), .CW(CW)) u_dlat (
    .clk(clk), .rst_n(rst_n), .fill_up(fill_up), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_byte(wr_byte), .data_q(data_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (!blank_n) line_q <= '0;
    else if (lp_fall) line_q <= data_q;
  end

  // R8
  blank_clears_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> line_q == '0);
  // R7
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && !lp_fall) |=> $stable(line_q));

  seg_level_map #(.COLS(COLS)) u_map (
    .line_q(line_q), .blank_n(blank_n), .frame_inv(frame_inv), .col_level(col_level)
  );
endmodule

// File: tb/seg_line_loader_tb.sv
module seg_line_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 160;

  logic clk = 0, rst_n = 0;
  logic shift_clk = 0, wide_mode = 0, fill_up = 1, latch_pulse = 0;
  logic blank_n = 1, frame_inv = 0, link_a_in = 1, link_b_in = 1;
  logic [7:0] bus_data = 0;
  logic link_a_out, link_a_oe, link_b_out, link_b_oe;
  logic [2*NC-1:0] col_level;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_line_loader u_dut (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .bus_data(bus_data),
    .wide_mode(wide_mode), .fill_up(fill_up), .latch_pulse(latch_pulse),
    .blank_n(blank_n), .frame_inv(frame_inv),
    .link_a_in(link_a_in), .link_a_out(link_a_out), .link_a_oe(link_a_oe),
    .link_b_in(link_b_in), .link_b_out(link_b_out), .link_b_oe(link_b_oe),
    .col_level(col_level)
  );

  // behavioural reference state
  bit m_ps, m_pl, m_sel, m_done, m_pulse, m_half;
  int m_bytes;
  bit [3:0] m_nib;
  bit m_dl[NC];
  bit m_ll[NC];

  function automatic int exp_level(int c);
    if (!blank_n) return 3;
    if (frame_inv) return m_ll[c] ? 0 : 1;
    return m_ll[c] ? 3 : 2;
  endfunction

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_ps = 0; m_pl = 0; m_sel = 0; m_done = 1; m_pulse = 0; m_half = 0; m_bytes = 0; m_nib = 0;
      foreach (m_dl[c]) begin m_dl[c] = 0; m_ll[c] = 0; end
    end else begin
      bit sf, lf, lin;
      sf = m_ps && !shift_clk;
      lf = m_pl && !latch_pulse;
      m_ps = shift_clk; m_pl = latch_pulse;
      lin = fill_up ? link_a_in : link_b_in;
      if (!blank_n) foreach (m_ll[c]) m_ll[c] = 0;
      else if (lf) foreach (m_ll[c]) m_ll[c] = m_dl[c];
      if (lf) begin
        m_bytes = 0; m_half = 0; m_sel = 0; m_done = 0; m_pulse = 0;
      end else if (sf) begin
        m_pulse = 0;
        if (!m_done && (m_sel || !lin)) begin
          m_sel = 1;
          if (wide_mode || m_half) begin
            bit [7:0] b;
            b = wide_mode ? bus_data : {bus_data[3:0], m_nib};
            for (int i = 0; i < 8; i++) begin
              int pos;
              pos = fill_up ? 8*m_bytes + i : NC - 1 - 8*m_bytes - i;
              m_dl[pos] = b[i];
            end
            m_half = 0;
            m_bytes++;
            if (m_bytes == NC/8) begin m_done = 1; m_sel = 0; m_pulse = 1; end
          end else begin
            m_half = 1; m_nib = bus_data[3:0];
          end
        end
      end
    end
    #(CLK_PERIOD/4);
    if (rst_n) begin
      int bad;
      bad = -1;
      for (int c = 0; c < NC; c++)
        if (bad < 0 && int'(col_level[2*c +: 2]) != exp_level(c)) bad = c;
      if (bad >= 0) chk("R9 per-clock column level", int'(col_level[2*bad +: 2]), exp_level(bad));
      else checks++;
      chk("R6 per-clock link_a_out", link_a_out, fill_up ? 1 : !m_pulse);
      chk("R6 per-clock link_b_out", link_b_out, fill_up ? !m_pulse : 1);
      chk("R6 per-clock link_a_oe", link_a_oe, !fill_up);
      chk("R6 per-clock link_b_oe", link_b_oe, fill_up);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // garbage on the bus except in the cycle the shift clock falls (R3)
  task automatic shift_one(logic [7:0] d);
    @(negedge clk); shift_clk = 1; bus_data = ~d;
    @(negedge clk); bus_data = 8'h5A ^ d;
    @(negedge clk); shift_clk = 0; bus_data = d;
    @(negedge clk); bus_data = ~d;
  endtask

  task automatic pulse_lp();
    @(negedge clk); latch_pulse = 1;
    @(negedge clk); @(negedge clk); latch_pulse = 0;
    @(negedge clk); @(negedge clk);
  endtask

  function automatic logic [7:0] pat(int k, int seed);
    return 8'((k * 37 + seed) & 8'hFF);
  endfunction

  function automatic int lvl(int c);
    return int'(col_level[2*c +: 2]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // R10: cleared latch, frame_inv low -> all V43 (2); links idle high
    chk("R10 reset col0", lvl(0), 2);
    chk("R10 reset col159", lvl(159), 2);
    chk("R10 reset link_b_out", link_b_out, 1);
    // R10: no data before a latch pulse
    link_a_in = 0;
    shift_one(8'hFF); shift_one(8'hFF);
    pulse_lp();
    chk("R10 nothing taken before first latch pulse col0", lvl(0), 2);

    // 4-bit, fill upward; two clocks before selection ignored (R5)
    fill_up = 1; wide_mode = 0; link_a_in = 1;
    shift_one(8'h0F); shift_one(8'h0F);
    link_a_in = 0;
    for (int k = 0; k < 20; k++) begin
      logic [7:0] b;
      b = pat(k, 3);
      shift_one({4'h0, b[3:0]});
      if (k == 0) link_a_in = 1;
      shift_one({4'h0, b[7:4]});
      if (k == 19) begin
        // R6: handoff low for one shift period
        chk("R6 handoff low after 160th bit", link_b_out, 0);
      end
    end
    @(negedge clk); shift_clk = 1; bus_data = 8'hFF;
    @(negedge clk); shift_clk = 0;
    @(negedge clk);
    chk("R6 handoff back high after next shift fall", link_b_out, 1);
    shift_one(8'hFF); shift_one(8'hFF);  // R5 extra clocks ignored
    pulse_lp();
    begin
      logic [7:0] b0, b19;
      b0 = pat(0, 3); b19 = pat(19, 3);
      chk("R1 R3 R4 nibble order col0", lvl(0), b0[0] ? 3 : 2);
      chk("R1 R4 nibble order col4", lvl(4), b0[4] ? 3 : 2);
      chk("R5 quota kept col159", lvl(159), b19[7] ? 3 : 2);
      frame_inv = 1; idle(1);
      chk("R9 inverted col0", lvl(0), b0[0] ? 0 : 1);
      chk("R9 inverted col1", lvl(1), b0[1] ? 0 : 1);
      frame_inv = 0;
    end

    // 8-bit, fill downward, link B input
    fill_up = 0; wide_mode = 1; link_b_in = 0;
    for (int k = 0; k < 20; k++) shift_one(pat(k, 91));
    link_b_in = 1;
    // R7: line latch unchanged before latch pulse
    begin
      logic [7:0] b0;
      b0 = pat(0, 3);
      chk("R7 line held before latch pulse", lvl(0), b0[0] ? 3 : 2);
    end
    pulse_lp();
    begin
      logic [7:0] b0, b19;
      b0 = pat(0, 91); b19 = pat(19, 91);
      chk("R2 R4 downward col159", lvl(159), b0[0] ? 3 : 2);
      chk("R2 R4 downward col152", lvl(152), b0[7] ? 3 : 2);
      chk("R2 R4 downward col0", lvl(0), b19[7] ? 3 : 2);
    end

    // R8: blanking while a line loads and across a latch pulse
    link_b_in = 0; blank_n = 0;
    for (int k = 0; k < 20; k++) shift_one(pat(k, 200));
    link_b_in = 1;
    chk("R8 blank forces V5 col3", lvl(3), 3);
    pulse_lp();
    blank_n = 1; idle(1);
    chk("R8 cleared line after blank col159", lvl(159), 2);
    pulse_lp();
    begin
      logic [7:0] b0;
      b0 = pat(0, 200);
      chk("R8 data latch loaded during blank col159", lvl(159), b0[0] ? 3 : 2);
    end

    // R10: reset mid-line
    link_b_in = 0;
    shift_one(8'hAA);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    idle(1);
    chk("R10 mid-line reset col0", lvl(0), 2);
    link_b_in = 1;
    idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule